// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Registers

This block holds the software-visible configuration space of a DRAM controller. It decodes a 4 KiB window of 32-bit words on a simple bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data.

Word 0 is a lock register. It keeps only one bit: whether the most recent value written to it was the unlock code. Until that bit is set, every other register ignores writes.

Word 1 is the controller's configuration word. Some of its fields are read-only, and written data in those positions is stored as zero. Its reset value carries a variant-dependent pattern and a 2-bit memory-size code derived from a size parameter. The remaining words up to the implemented count are plain storage. The silicon variant is a static parameter that selects the read-only mask, the reset pattern and the size encoding.

Top module: `keyed_cfg_regs`

## Requirements
- R1: After reset, word 0 reads 0 (locked), word 1 reads its variant reset value, and every other implemented word reads 0.
- R2: Writing exactly 0xFC600309 to word 0 makes it read 1. Any other value, including 0x039FFCF6, makes it read 0. Word 0 accepts writes whether locked or not.
- R3: While word 0 reads 0, writes to word 1 and to plain words leave them unchanged.
- R4: While word 0 reads 1, plain words 2 to NUM_REGS-1 store and return the full 32-bit written value.
- R5: A write to word 1 stores the data with its read-only bits forced to 0. Variant A (VARIANT=0) uses mask 0xFFFFF84C (bits 31:11, 6, 3:2). Variant B (VARIANT=1) uses mask 0xF00FC04C (bits 31:28, 19, 18:14, 6, 3:2).
- R6: The word 1 reset value for variant A is 0x40 OR the size code, with 64/128/256/512 MiB coded as 0/1/2/3. For variant B it is 0x1000000C OR the size code, with 128/256/512/1024 MiB coded as 0/1/2/3. An unlisted size falls back to code 2 for both variants (256 MiB for A, 512 MiB for B).
- R7: A word index (address bits 11:2) at or beyond NUM_REGS reads 0, and writes to it change no register.
- R8: Read data appears on the cycle after the read strobe and holds while no read is strobed. A same-cycle write and read of one word returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address; bits 11:2 give the word index |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |

## Verification
The bench builds two instances side by side on a shared bus. One is variant B at 1024 MiB, the top size code, where the version field and the upper read-only bits come into play. The other is variant A at an illegal 300 MiB, which exercises the fallback size code and the wide 31:11 read-only mask. Both instances see the same lock sequences, so gating, relocking with the inverted code and out-of-range decode are compared across both masks in one run.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = ADDR_W - 2;

  localparam int VARIANT_A = 0;
  localparam int VARIANT_B = 1;

  localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'hFC60_0309;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic             cfgWr;
    logic             plainWr;
    logic             rdEn;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;

  function automatic logic [DATA_W-1:0] cfgRoMask(input int variant);
    if (variant == VARIANT_B) return 32'hF00F_C04C;
    return 32'hFFFF_F84C;
  endfunction

  function automatic logic [1:0] sizeCode(input int variant, input int mib);
    logic [1:0] code;
    code = 2'd2;
    if (variant == VARIANT_B) begin
      case (mib)
        128:     code = 2'd0;
        256:     code = 2'd1;
        512:     code = 2'd2;
        1024:    code = 2'd3;
        default: code = 2'd2;
      endcase
    end else begin
      case (mib)
        64:      code = 2'd0;
        128:     code = 2'd1;
        256:     code = 2'd2;
        512:     code = 2'd3;
        default: code = 2'd2;
      endcase
    end
    return code;
  endfunction

  function automatic logic [DATA_W-1:0] cfgResetVal(input int variant, input int mib);
    logic [DATA_W-1:0] base;
    base = (variant == VARIANT_B) ? 32'h1000_000C : 32'h0000_0040;
    return base | {30'd0, sizeCode(variant, mib)};
  endfunction

endpackage

// File: rtl/keyed_cfg_ctrl.sv
module keyed_cfg_ctrl
  import keyed_cfg_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output cfgStrobe_t        strb,
  output logic              unlocked
);

  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(NUM_REGS);
  localparam logic [IDX_W-1:0] KEY_IDX   = '0;
  localparam logic [IDX_W-1:0] CFG_IDX   = IDX_W'(1);

  logic [IDX_W-1:0] wordIdx;
  logic [1:0]       unusedLowAddr;
  logic             inRange;
  logic             keyWr;
  logic             keyMatch;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowAddr = busAddr[1:0];
  assign inRange       = wordIdx < LIMIT_IDX;
  assign keyWr         = busWrEn && (wordIdx == KEY_IDX);
  assign keyMatch      = (busWrData == UNLOCK_CODE);

  always_comb begin
    strb         = '0;
    strb.idx     = wordIdx;
    strb.rdEn    = busRdEn;
    strb.cfgWr   = busWrEn && unlocked && (wordIdx == CFG_IDX);
    strb.plainWr = busWrEn && unlocked && inRange && (wordIdx > CFG_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      unlocked <= 1'b0;
    else if (keyWr) unlocked <= keyMatch;
  end

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[ADDR_W-1:2] == '0 && busWrData == 32'hFC60_0309) |=> unlocked);

  // R2
  key_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[ADDR_W-1:2] == '0 && busWrData != 32'hFC60_0309) |=> !unlocked);

  // R7
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[ADDR_W-1:2] >= LIMIT_IDX) |-> !(strb.cfgWr || strb.plainWr));

  // R3
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !(strb.cfgWr || strb.plainWr));

endmodule

// File: rtl/keyed_cfg_dp.sv
module keyed_cfg_dp
  import keyed_cfg_pkg::*;
#(
  parameter int VARIANT  = VARIANT_B,
  parameter int DRAM_MIB = 512,
  parameter int NUM_REGS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  localparam int               SEL_W     = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0] LIMIT_IDX = IDX_W'(NUM_REGS);
  localparam logic [DATA_W-1:0] CFG_RST  = cfgResetVal(VARIANT, DRAM_MIB);

  logic [DATA_W-1:0] roMask;
  logic [DATA_W-1:0] cfgReg;
  logic [DATA_W-1:0] plainMem [NUM_REGS];
  logic [DATA_W-1:0] rdNext;

  generate
    if (VARIANT == VARIANT_B) begin : g_mask_b
      assign roMask = cfgRoMask(VARIANT_B);
    end else begin : g_mask_a
      assign roMask = cfgRoMask(VARIANT_A);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cfgReg <= CFG_RST;
    else if (strb.cfgWr) cfgReg <= wrData & ~roMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) plainMem[i] <= '0;
    end else if (strb.plainWr) begin
      plainMem[strb.idx[SEL_W-1:0]] <= wrData;
    end
  end

  always_comb begin
    if (strb.idx == '0)              rdNext = {{(DATA_W-1){1'b0}}, unlocked};
    else if (strb.idx == IDX_W'(1))  rdNext = cfgReg;
    else if (strb.idx < LIMIT_IDX)   rdNext = plainMem[strb.idx[SEL_W-1:0]];
    else                             rdNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (strb.rdEn) rdData <= rdNext;
  end

  // R3
  cfg_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |=> $stable(cfgReg));

  // R5
  cfg_ro_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWr |=> ((cfgReg & cfgRoMask(VARIANT)) == '0));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/keyed_cfg_regs.sv
module keyed_cfg_regs
  import keyed_cfg_pkg::*;
#(
  parameter int VARIANT  = VARIANT_B,
  parameter int DRAM_MIB = 512,
  parameter int NUM_REGS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  input  logic        busRdEn,
  output logic [31:0] busRdData
);

  cfgStrobe_t strb;
  logic       unlocked;

  keyed_cfg_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .strb      (strb),
    .unlocked  (unlocked)
  );

  keyed_cfg_dp #(
    .VARIANT  (VARIANT),
    .DRAM_MIB (DRAM_MIB),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .unlocked (unlocked),
    .wrData   (busWrData),
    .rdData   (busRdData)
  );

endmodule

// File: tb/keyed_cfg_regs_tb.sv
module keyed_cfg_regs_tb;

  localparam logic [31:0] MAGIC = 32'hFC60_0309;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] rdB;
  logic [31:0] rdA;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  // variant B, 1024 MiB
  keyed_cfg_regs #(.VARIANT(1), .DRAM_MIB(1024), .NUM_REGS(64)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdB));

  // variant A, illegal 300 MiB
  keyed_cfg_regs #(.VARIANT(0), .DRAM_MIB(300), .NUM_REGS(64)) u_dutA (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(rdA));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] vb, output logic [31:0] va);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    vb = rdB; va = rdA;
  endtask

  task automatic testReset();
    logic [31:0] b, a;
    rd(12'h000, b, a); check("R1 key B", b, 0); check("R1 key A", a, 0);
    // R6 size codes: B 1024 -> 3, A fallback -> 2
    rd(12'h004, b, a); check("R1/R6 cfg B", b, 32'h1000_000F); check("R1/R6 cfg A", a, 32'h0000_0042);
    rd(12'h014, b, a); check("R1 plain B", b, 0); check("R1 plain A", a, 0);
  endtask

  task automatic testLocked();
    logic [31:0] b, a;
    wr(12'h014, 32'hDEAD_BEEF);
    wr(12'h004, 32'h0000_0001);
    rd(12'h014, b, a); check("R3 plain B", b, 0); check("R3 plain A", a, 0);
    rd(12'h004, b, a); check("R3 cfg B", b, 32'h1000_000F); check("R3 cfg A", a, 32'h0000_0042);
  endtask

  task automatic testKey();
    logic [31:0] b, a;
    wr(12'h000, MAGIC);
    rd(12'h000, b, a); check("R2 magic B", b, 1); check("R2 magic A", a, 1);
    wr(12'h000, 32'h1234_5678);
    rd(12'h000, b, a); check("R2 other B", b, 0); check("R2 other A", a, 0);
    wr(12'h000, MAGIC);
    rd(12'h000, b, a); check("R2 reopen B", b, 1);
  endtask

  task automatic testPlain();
    logic [31:0] b, a;
    wr(12'h014, 32'hA5A5_5A5A);
    wr(12'h0FC, 32'h0BAD_F00D);
    rd(12'h014, b, a); check("R4 word5 B", b, 32'hA5A5_5A5A); check("R4 word5 A", a, 32'hA5A5_5A5A);
    rd(12'h0FC, b, a); check("R4 word63 B", b, 32'h0BAD_F00D); check("R4 word63 A", a, 32'h0BAD_F00D);
  endtask

  task automatic testMask();
    logic [31:0] b, a;
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, b, a); check("R5 ones B", b, 32'h0FF0_3FB3); check("R5 ones A", a, 32'h0000_07B3);
    wr(12'h004, 32'h1234_5678);
    rd(12'h004, b, a); check("R5 pat B", b, 32'h1234_5678 & ~32'hF00F_C04C);
    check("R5 pat A", a, 32'h1234_5678 & ~32'hFFFF_F84C);
  endtask

  task automatic testRange();
    logic [31:0] b, a;
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'h5555_5555);
    rd(12'h100, b, a); check("R7 idx64 B", b, 0); check("R7 idx64 A", a, 0);
    rd(12'hFFC, b, a); check("R7 top B", b, 0);
    rd(12'h000, b, a); check("R7 key kept B", b, 1);
    rd(12'h014, b, a); check("R7 word5 kept A", a, 32'hA5A5_5A5A);
  endtask

  task automatic testTiming();
    logic [31:0] b, a;
    busAddr = 12'h014; busWrData = 32'h7777_0000; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    check("R8 old value B", rdB, 32'hA5A5_5A5A);
    busAddr = 12'h0FC;
    @(negedge clk);
    check("R8 hold B", rdB, 32'hA5A5_5A5A);
    rd(12'h014, b, a); check("R8 new value A", a, 32'h7777_0000);
  endtask

  task automatic testRelock();
    logic [31:0] b, a;
    wr(12'h000, ~MAGIC);
    rd(12'h000, b, a); check("R2 inverse B", b, 0); check("R2 inverse A", a, 0);
    wr(12'h014, 32'h0000_0000);
    rd(12'h014, b, a); check("R3 relocked B", b, 32'h7777_0000);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocked();
    testKey();
    testPlain();
    testMask();
    testRange();
    testTiming();
    testRelock();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule